// File: doc/BRIEF.md
# Daisy-Chain Depth Token Control

This block is the per-device controller that lets several identical FIFO devices be wired in a ring so that together they behave as one deeper FIFO. Two tokens travel around the ring independently: one grants the right to write and the other grants the right to read. A device accepts local write or read requests only while it holds the matching token. When it accesses the last location of its memory, it hands that token to the next device with a one-cycle low pulse on the matching expansion output.

The memory array is outside the block. Only one write pointer and one read pointer are kept here. Each pointer drives the address for the memory and marks the last location. The head of the ring is chosen by a strap input. If either expansion input is tied low, the device works alone. It then ignores tokens, and its write expansion output carries a half-full indication instead.

Top module: `depth_chain_ctrl`

## Requirements
- R1: While reset is asserted, and during the first cycle after it is released, both enables are low and both expansion outputs are high. The first rising edge after release fixes the operating mode and the token ownership.
- R2: In chain mode, the device with `lead_ni` low holds both tokens from the first edge after release. Any device with `lead_ni` high holds neither token, and its enables stay low even while requests are present.
- R3: `wr_en_o` is high only when `wr_req_i` is high and the device holds the write token. In single mode the token is not needed.
- R4: `rd_en_o` is high only when `rd_req_i` is high and the device holds the read token. In single mode the token is not needed.
- R5: In chain mode, an accepted write at address DEPTH-1 drives `wr_xout_no` low for exactly the following cycle. The write token is released at that same edge.
- R6: In chain mode, an accepted read at address DEPTH-1 drives `rd_xout_no` low for exactly the following cycle. The read token is released at that same edge.
- R7: A low cycle on `wr_xin_ni` (or `rd_xin_ni`) makes the device take the write (or read) token at the end of that cycle. The device accepts requests from the next cycle on, so each handoff leaves one cycle with no owner.
- R8: The write and read tokens move independently of each other. Both can be handed off in the same cycle by different devices.
- R9: Each pointer starts at 0, advances by one on each accepted access, wraps from DEPTH-1 to 0, and holds when no access is accepted.
- R10: If either expansion input is low at the mode-fixing edge, the device enters single mode. In single mode, token inputs are ignored, `rd_xout_no` stays high, and `wr_xout_no` equals the inverse of `half_full_i` as sampled at the previous edge.
- R11: In a ring of devices with equal depth, data is read back in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_ni | input | 1 | Strap, low on the device that starts the ring |
| wr_xin_ni | input | 1 | Write token pulse from the previous device (active low) |
| rd_xin_ni | input | 1 | Read token pulse from the previous device (active low) |
| wr_req_i | input | 1 | Local write request |
| rd_req_i | input | 1 | Local read request |
| half_full_i | input | 1 | Occupancy above half, used in single mode |
| wr_en_o | output | 1 | Write accepted this cycle |
| rd_en_o | output | 1 | Read accepted this cycle |
| wr_addr_o | output | AW | Write pointer |
| rd_addr_o | output | AW | Read pointer |
| wr_xout_no | output | 1 | Write token pulse to the next device, or half-full indication in single mode |
| rd_xout_no | output | 1 | Read token pulse to the next device |

## Verification
The write handoff and the read handoff can fall in the same cycle on different devices of the ring. Each then fires its own expansion pulse, and two different neighbours take tokens on the next edge. The bench reaches this case by pausing writes for a few cycles while reads continue, so that one device's last write lines up with another device's last read. It judges the result by the expected accepting device, the pointer and the expansion level of every device in every cycle, and by the order in which data comes back.

// File: rtl/depth_chain_pkg.sv
package depth_chain_pkg;
  typedef enum logic [1:0] {
    MODE_BOOT   = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_SINGLE = 2'd2
  } chain_mode_e;
endpackage

// File: rtl/depth_chain_mode.sv
module depth_chain_mode
  import depth_chain_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_xin_ni,
  input  logic        rd_xin_ni,
  output chain_mode_e mode_o
);
  chain_mode_e mode_q;

  // mode is fixed once, on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BOOT;
    end else if (mode_q == MODE_BOOT) begin
      mode_q <= (!wr_xin_ni || !rd_xin_ni) ? MODE_SINGLE : MODE_CHAIN;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/depth_chain_ptr.sv
module depth_chain_ptr #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (adv_i) begin
      addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == LAST);
endmodule

// File: rtl/depth_chain_token.sv
module depth_chain_token
  import depth_chain_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  chain_mode_e mode_i,
  input  logic        head_i,
  input  logic        take_ni,
  input  logic        req_i,
  input  logic        last_i,
  output logic        en_o,
  output logic        fire_no
);
  logic own_q;
  logic fire_nq;
  logic chain;
  logic single;
  logic fire;

  assign chain  = (mode_i == MODE_CHAIN);
  assign single = (mode_i == MODE_SINGLE);
  assign en_o   = req_i && (single || (chain && own_q));
  assign fire   = chain && en_o && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= 1'b0;
      fire_nq <= 1'b1;
    end else begin
      if (mode_i == MODE_BOOT) own_q <= head_i;
      else                     own_q <= !take_ni || (own_q && !fire);
      fire_nq <= !fire;
    end
  end

  assign fire_no = fire_nq;
endmodule

// File: rtl/depth_chain_ctrl.sv
module depth_chain_ctrl
  import depth_chain_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lead_ni,
  input  logic          wr_xin_ni,
  input  logic          rd_xin_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          half_full_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_xout_no,
  output logic          rd_xout_no
);
  localparam int NDIR = 2;  // 0 = write, 1 = read

  chain_mode_e     mode;
  logic [NDIR-1:0] req;
  logic [NDIR-1:0] take_n;
  logic [NDIR-1:0] en;
  logic [NDIR-1:0] last;
  logic [NDIR-1:0] fire_n;
  logic [AW-1:0]   addr [NDIR];
  logic            hf_nq;

  assign req    = {rd_req_i, wr_req_i};
  assign take_n = {rd_xin_ni, wr_xin_ni};

  depth_chain_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_xin_ni(wr_xin_ni),
    .rd_xin_ni(rd_xin_ni),
    .mode_o   (mode)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    depth_chain_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (en[d]),
      .addr_o(addr[d]),
      .last_o(last[d])
    );

    depth_chain_token u_tok (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .head_i (!lead_ni),
      .take_ni(take_n[d]),
      .req_i  (req[d]),
      .last_i (last[d]),
      .en_o   (en[d]),
      .fire_no(fire_n[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hf_nq <= 1'b1;
    else         hf_nq <= !half_full_i;
  end

  assign wr_en_o    = en[0];
  assign rd_en_o    = en[1];
  assign wr_addr_o  = addr[0];
  assign rd_addr_o  = addr[1];
  // single mode reuses the write expansion pin as a half-full indication
  assign wr_xout_no = (mode == MODE_SINGLE) ? hf_nq : fire_n[0];
  assign rd_xout_no = fire_n[1];
endmodule

// File: rtl/depth_chain_ctrl_chk.sv
module depth_chain_ctrl_chk
  import depth_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lead_ni,
  input logic          wr_xin_ni,
  input logic          rd_xin_ni,
  input logic          wr_req_i,
  input logic          rd_req_i,
  input logic          half_full_i,
  input logic          wr_en_o,
  input logic          rd_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wr_xout_no,
  input logic          rd_xout_no,
  input chain_mode_e   mode_i
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_BOOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BOOT) |-> (!wr_en_o && !rd_en_o && wr_xout_no && rd_xout_no)); // R1

  AST_TAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_BOOT && mode_i == MODE_CHAIN && lead_ni) |-> (!wr_en_o && !rd_en_o)); // R2

  AST_WR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_req_i); // R3

  AST_RD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_req_i); // R4

  AST_WR_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CHAIN && wr_en_o && wr_addr_o == LAST && wr_xin_ni)
      |=> (!wr_xout_no && !wr_en_o)); // R5

  AST_RD_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CHAIN && rd_en_o && rd_addr_o == LAST && rd_xin_ni)
      |=> (!rd_xout_no && !rd_en_o)); // R6

  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != LAST) |=> (wr_addr_o == AW'($past(wr_addr_o) + 1'b1))); // R9

  AST_WR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == LAST) |=> (wr_addr_o == '0)); // R9

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |=> $stable(rd_addr_o)); // R9

  AST_SOLO_RD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SINGLE) |-> rd_xout_no); // R10

  AST_SOLO_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_SINGLE) |-> (wr_xout_no == !$past(half_full_i))); // R10
endmodule

bind depth_chain_ctrl depth_chain_ctrl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lead_ni    (lead_ni),
  .wr_xin_ni  (wr_xin_ni),
  .rd_xin_ni  (rd_xin_ni),
  .wr_req_i   (wr_req_i),
  .rd_req_i   (rd_req_i),
  .half_full_i(half_full_i),
  .wr_en_o    (wr_en_o),
  .rd_en_o    (rd_en_o),
  .wr_addr_o  (wr_addr_o),
  .rd_addr_o  (rd_addr_o),
  .wr_xout_no (wr_xout_no),
  .rd_xout_no (rd_xout_no),
  .mode_i     (mode)
);

// File: tb/depth_chain_ctrl_bench.sv
`timescale 1ns/1ps
module depth_chain_ctrl_bench;
  localparam int NDEV  = 3;
  localparam int DEPTH = 4;
  localparam int NROW  = 34;
  localparam int NONE  = 3;

  // row: {wr_req, rd_req, expected writer[1:0], expected reader[1:0]}, 3 = nobody
  localparam logic [5:0] VEC [NROW] = '{
    6'b10_00_11, 6'b10_00_11, 6'b10_00_11, 6'b10_00_11,
    6'b10_11_11, 6'b10_01_11, 6'b10_01_11, 6'b10_01_11,
    6'b11_01_00, 6'b11_11_00, 6'b11_10_00, 6'b11_10_00,
    6'b11_10_11, 6'b11_10_01, 6'b11_11_01, 6'b11_00_01,
    6'b11_00_01, 6'b11_00_11, 6'b11_00_10, 6'b11_11_10,
    6'b11_01_10, 6'b11_01_10, 6'b11_01_11, 6'b11_01_00,
    6'b01_11_00, 6'b01_11_00, 6'b01_11_00, 6'b01_11_11,
    6'b11_10_01, 6'b11_10_01, 6'b11_10_01, 6'b11_10_01,
    6'b11_11_11, 6'b11_00_10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic s_wr_req = 1'b0, s_rd_req = 1'b0, s_hf = 1'b0;

  logic [NDEV-1:0] wen, ren, wxo_n, rxo_n;
  logic [1:0]      waddr [NDEV];
  logic [1:0]      raddr [NDEV];
  logic            s_wen, s_ren, s_wxo_n, s_rxo_n;
  logic [1:0]      s_waddr, s_raddr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NDEV; g++) begin : g_ring
    depth_chain_ctrl #(.DEPTH(DEPTH)) u_depth_chain_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .lead_ni    (g != 0),
      .wr_xin_ni  (wxo_n[(g + NDEV - 1) % NDEV]),
      .rd_xin_ni  (rxo_n[(g + NDEV - 1) % NDEV]),
      .wr_req_i   (wr_req),
      .rd_req_i   (rd_req),
      .half_full_i(1'b0),
      .wr_en_o    (wen[g]),
      .rd_en_o    (ren[g]),
      .wr_addr_o  (waddr[g]),
      .rd_addr_o  (raddr[g]),
      .wr_xout_no (wxo_n[g]),
      .rd_xout_no (rxo_n[g])
    );
  end

  depth_chain_ctrl #(.DEPTH(DEPTH)) u_depth_chain_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .lead_ni    (1'b1),
    .wr_xin_ni  (1'b0),
    .rd_xin_ni  (1'b1),
    .wr_req_i   (s_wr_req),
    .rd_req_i   (s_rd_req),
    .half_full_i(s_hf),
    .wr_en_o    (s_wen),
    .rd_en_o    (s_ren),
    .wr_addr_o  (s_waddr),
    .rd_addr_o  (s_raddr),
    .wr_xout_no (s_wxo_n),
    .rd_xout_no (s_rxo_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int who(input logic [NDEV-1:0] v);
    int w = NONE;
    for (int i = 0; i < NDEV; i++) if (v[i]) w = (w == NONE) ? i : 7;
    return w;
  endfunction

  logic [7:0] mem [NDEV][DEPTH];
  logic [7:0] sb [64];

  initial begin
    int wptr [NDEV];
    int rptr [NDEV];
    int wfire, rfire, sb_wr, sb_rd, ew, er, aw, ar;
    logic [7:0] wdata;
    for (int i = 0; i < NDEV; i++) begin wptr[i] = 0; rptr[i] = 0; end
    wfire = NONE; rfire = NONE; sb_wr = 0; sb_rd = 0; wdata = 8'h40;

    // reset state
    wr_req = 1'b1; rd_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(wen == '0 && ren == '0, "R1 enables in reset", int'({wen, ren}), 0);
    chk(wxo_n == '1 && rxo_n == '1, "R1 expansion outputs in reset", int'({wxo_n, rxo_n}), 63);
    rst_n = 1'b1; rd_req = 1'b0;
    #1;
    chk(wen == '0, "R1 no write before mode edge", int'(wen), 0);
    chk(s_wen == 1'b0, "R1 single device waits for mode edge", int'(s_wen), 0);

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      wr_req = VEC[r][5]; rd_req = VEC[r][4];
      ew = int'(VEC[r][3:2]); er = int'(VEC[r][1:0]);
      #1;
      aw = who(wen); ar = who(ren);
      chk(aw == ew, $sformatf("R2 R3 R7 writer row %0d", r), aw, ew);
      chk(ar == er, $sformatf("R2 R4 R7 reader row %0d", r), ar, er);
      for (int d = 0; d < NDEV; d++) begin
        chk(wxo_n[d] == (wfire != d), $sformatf("R5 write pulse dev %0d row %0d", d, r),
            int'(wxo_n[d]), int'(wfire != d));
        chk(rxo_n[d] == (rfire != d), $sformatf("R6 R8 read pulse dev %0d row %0d", d, r),
            int'(rxo_n[d]), int'(rfire != d));
      end
      wfire = NONE; rfire = NONE;
      if (ew != NONE) begin
        chk(int'(waddr[ew]) == wptr[ew], $sformatf("R9 write addr row %0d", r), int'(waddr[ew]), wptr[ew]);
        mem[ew][waddr[ew]] = wdata;
        sb[sb_wr] = wdata; sb_wr++; wdata++;
        if (wptr[ew] == DEPTH - 1) wfire = ew;
        wptr[ew] = (wptr[ew] + 1) % DEPTH;
      end
      if (er != NONE) begin
        chk(int'(raddr[er]) == rptr[er], $sformatf("R9 read addr row %0d", r), int'(raddr[er]), rptr[er]);
        chk(mem[er][raddr[er]] == sb[sb_rd], $sformatf("R11 data order row %0d", r),
            int'(mem[er][raddr[er]]), int'(sb[sb_rd]));
        sb_rd++;
        if (rptr[er] == DEPTH - 1) rfire = er;
        rptr[er] = (rptr[er] + 1) % DEPTH;
      end
    end
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;

    // single mode: tokens ignored, pointers wrap
    for (int k = 0; k < 6; k++) begin
      s_wr_req = 1'b1; s_rd_req = 1'b1;
      #1;
      chk(s_wen && s_ren, "R10 single device always enabled", int'({s_wen, s_ren}), 3);
      chk(int'(s_waddr) == k % DEPTH, "R9 single write wrap", int'(s_waddr), k % DEPTH);
      chk(s_rxo_n == 1'b1, "R10 read expansion idle", int'(s_rxo_n), 1);
      @(negedge clk);
    end
    s_wr_req = 1'b0; s_rd_req = 1'b0;
    #1;
    chk(int'(s_waddr) == 2, "R9 pointer holds when idle", int'(s_waddr), 2);
    @(negedge clk);
    chk(int'(s_waddr) == 2, "R9 pointer holds when idle", int'(s_waddr), 2);

    // half-full on write expansion output, one edge late
    s_hf = 1'b1; #1;
    chk(s_wxo_n == 1'b1, "R10 half-full not yet sampled", int'(s_wxo_n), 1);
    @(negedge clk);
    chk(s_wxo_n == 1'b0, "R10 half-full shown", int'(s_wxo_n), 0);
    s_hf = 1'b0;
    @(negedge clk);
    chk(s_wxo_n == 1'b1, "R10 half-full cleared", int'(s_wxo_n), 1);
    chk(s_rxo_n == 1'b1, "R10 read expansion stays high", int'(s_rxo_n), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule